// File: doc/BRIEF.md
# Pipelined CORDIC Sine Generator

This block turns an unsigned phase word into a signed sine sample through a chain of CORDIC micro-rotations, one per pipeline stage. The phase word spans one full turn: code 0 is 0 rad, and code 2^DATA_W would be 2π. A new phase can be accepted on every clock, and a sample leaves on every clock. An opaque side word enters with each phase and comes out with the sample computed from that phase, so that tags, strobes or channel numbers stay aligned without any extra logic around the block.

The entry register folds the phase into the convergence range of the rotator using the two top phase bits. DATA_W rotation stages follow. Each stage shifts the X or Y operand by its stage index before it adds or subtracts, and steps a residual angle by an arctangent constant that is computed when the design is elaborated. X, Y and the residual angle carry guard bits below the sample LSB. The starting X value holds the CORDIC gain correction and is trimmed so that the peak falls three codes below full scale. A registered formatter then converts the DATA_W-bit internal word to OUT_W bits. When it narrows, it rounds to nearest with ties to even. When it widens, it shifts left. When the widths are equal, it passes the word unchanged.

Top module: `cordic_sine_gen`

## Requirements
- R1: While rst_n is low, and for the first DATA_W+2 rising edges after release, sine_out and side_out are zero. A phase captured on a rising edge appears DATA_W+1 edges later, which is a latency of DATA_W+2 register stages.
- R2: Let A = 2^(DATA_W-1)-3. With OUT_W equal to DATA_W, each sample is within 4 LSB of A·sin(2π·phase/2^DATA_W).
- R3: side_out equals the side_in value that was captured together with the phase of the sample shown, with the same latency as the sample.
- R4: All four quadrants are covered, as selected by phase bits [DATA_W-1:DATA_W-2]. Phase codes 0, 2^(DATA_W-2), 2^(DATA_W-1) and 3·2^(DATA_W-2), and their neighbours, give 0, +A, 0 and −A within the R2 bound.
- R5: sine_out never takes its most negative code (−2^(OUT_W-1)). The internal X and Y stay within 2^(DATA_W-1) sample LSB plus 8.
- R6: With OUT_W below DATA_W, the internal word is divided by 2^(DATA_W-OUT_W) and rounded to nearest, with exact ties going to the even code. The result saturates symmetrically at ±(2^(OUT_W-1)-1). The accuracy is within 2 output LSB of A·2^(OUT_W-DATA_W)·sin.
- R7: With OUT_W above DATA_W, the output is the internal word shifted left by OUT_W-DATA_W. Its low OUT_W-DATA_W bits are zero, and it is within 4·2^(OUT_W-DATA_W) LSB of the scaled sine.
- R8: With OUT_W equal to DATA_W, the output is the internal word with no rounding applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of all pipeline registers |
| phase_in | input | DATA_W | Unsigned phase, full turn = 2^DATA_W |
| side_in | input | SIDE_W | Side word that travels with the phase |
| sine_out | output | OUT_W | Signed sine sample |
| side_out | output | SIDE_W | Side word aligned with sine_out |

## Verification
The bench drives the exact quadrant boundaries and the codes on either side of them. A wrong quadrant fold shows up there as a sign flip, or as a sample that is off by a quarter turn. It also sweeps the whole circle and then applies pseudo-random phases, all through three width configurations: equal, widening and narrowing. A latency off by one misaligns both the sample and the side word against the queue model. A gain constant without the trim can push the peak into the most negative code. A stage that shifts the sum instead of the operand, or uses a wrong arctangent constant, leaves errors of many LSB. In the widening configuration the low bits of every sample are checked to be zero, which exposes a formatter that sign-fills or rounds when it should only shift.

// File: rtl/cordic_sine_pkg.sv
`timescale 1ns/1ps
package cordic_sine_pkg;

  // guard bits kept below the sample LSB in X and Y
  localparam int FRAC_W = 4;
  // guard bits kept below the phase LSB in the residual angle
  localparam int ANG_G = 4;
  // distance of the peak below full scale, in sample LSB
  localparam int PEAK_MARGIN = 2;

  // arctan(2^-i) in radians, by power series (i = 0 is the closed form)
  function automatic real atan_pow2(input int i);
    real x, x2, term, acc;
    if (i == 0) return 0.7853981633974483;
    x = 1.0;
    for (int j = 0; j < i; j++) x = x / 2.0;
    x2 = x * x;
    term = x;
    acc = 0.0;
    for (int n = 0; n < 40; n++) begin
      if ((n % 2) == 0) acc = acc + term / real'(2 * n + 1);
      else              acc = acc - term / real'(2 * n + 1);
      term = term * x2;
    end
    return acc;
  endfunction

  // stage angle in residual units (2^(dw+ANG_G) units per turn), rounded
  function automatic int atan_units(input int i, input int dw);
    real scale;
    scale = 1.0;
    for (int j = 0; j < dw + ANG_G; j++) scale = scale * 2.0;
    return $rtoi(atan_pow2(i) * scale / 6.283185307179586 + 0.5);
  endfunction

  // product of the stage stretch factors sqrt(1 + 4^-i) over n stages
  function automatic real cordic_gain(input int n);
    real g2, g, p;
    g2 = 1.0;
    p  = 1.0;
    for (int i = 0; i < n; i++) begin
      g2 = g2 * (1.0 + p);
      p  = p / 4.0;
    end
    g = g2;
    for (int k = 0; k < 30; k++) g = 0.5 * (g + g2 / g);
    return g;
  endfunction

  // starting X with gain correction, trimmed below full scale
  function automatic int start_x(input int dw);
    real a;
    a = 1.0;
    for (int j = 0; j < dw - 1; j++) a = a * 2.0;
    a = a - 1.0 - real'(PEAK_MARGIN);
    for (int j = 0; j < FRAC_W; j++) a = a * 2.0;
    return $rtoi(a / cordic_gain(dw));
  endfunction

endpackage

// File: rtl/cordic_sine_prerot.sv
`timescale 1ns/1ps
module cordic_sine_prerot import cordic_sine_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int SIDE_W = 8,
  parameter int XY_W   = DATA_W + FRAC_W + 2,
  parameter int ANG_W  = DATA_W + ANG_G + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       phase,
  input  logic [SIDE_W-1:0]       side,
  output logic signed [XY_W-1:0]  x_o,
  output logic signed [XY_W-1:0]  y_o,
  output logic signed [ANG_W-1:0] z_o,
  output logic [SIDE_W-1:0]       side_o
);
  localparam logic signed [XY_W-1:0]  X0      = XY_W'(start_x(DATA_W));
  localparam logic signed [ANG_W-1:0] QUARTER = ANG_W'(longint'(1) << (DATA_W - 2 + ANG_G));

  logic [1:0]              quad;
  logic signed [ANG_W-1:0] z_full, z_n;
  logic signed [XY_W-1:0]  x_n, y_n;

  assign quad   = phase[DATA_W-1 -: 2];
  // phase read as a signed fraction of a turn, with angle guard bits
  assign z_full = {{2{phase[DATA_W-1]}}, phase, {ANG_G{1'b0}}};

  always_comb begin
    x_n = X0;
    y_n = '0;
    z_n = z_full;
    case (quad)
      2'b01: begin          // second quadrant: start at +90 degrees
        x_n = '0;
        y_n = X0;
        z_n = z_full - QUARTER;
      end
      2'b10: begin          // third quadrant: start at -90 degrees
        x_n = '0;
        y_n = -X0;
        z_n = z_full + QUARTER;
      end
      default: ;            // first and fourth quadrant already converge
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
      side_o <= '0;
    end else begin
      x_o    <= x_n;
      y_o    <= y_n;
      z_o    <= z_n;
      side_o <= side;
    end
  end
endmodule

// File: rtl/cordic_sine_stage.sv
`timescale 1ns/1ps
module cordic_sine_stage import cordic_sine_pkg::*; #(
  parameter int IDX    = 0,
  parameter int DATA_W = 16,
  parameter int SIDE_W = 8,
  parameter int XY_W   = DATA_W + FRAC_W + 2,
  parameter int ANG_W  = DATA_W + ANG_G + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [XY_W-1:0]  x_i,
  input  logic signed [XY_W-1:0]  y_i,
  input  logic signed [ANG_W-1:0] z_i,
  input  logic [SIDE_W-1:0]       side_i,
  output logic signed [XY_W-1:0]  x_o,
  output logic signed [XY_W-1:0]  y_o,
  output logic signed [ANG_W-1:0] z_o,
  output logic [SIDE_W-1:0]       side_o
);
  localparam logic signed [ANG_W-1:0] ANGLE = ANG_W'(atan_units(IDX, DATA_W));

  logic signed [XY_W-1:0] x_sh, y_sh;
  logic                   ccw;

  // operands are scaled before the add, keeping the adder input narrow
  assign x_sh = x_i >>> IDX;
  assign y_sh = y_i >>> IDX;
  assign ccw  = ~z_i[ANG_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
      side_o <= '0;
    end else begin
      side_o <= side_i;
      if (ccw) begin
        x_o <= x_i - y_sh;
        y_o <= y_i + x_sh;
        z_o <= z_i - ANGLE;
      end else begin
        x_o <= x_i + y_sh;
        y_o <= y_i - x_sh;
        z_o <= z_i + ANGLE;
      end
    end
  end
endmodule

// File: rtl/cordic_sine_fmt.sv
`timescale 1ns/1ps
module cordic_sine_fmt #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16,
  parameter int SIDE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] core_i,
  input  logic [SIDE_W-1:0]        side_i,
  output logic signed [OUT_W-1:0]  sine_o,
  output logic [SIDE_W-1:0]        side_o
);
  logic signed [OUT_W-1:0] res;

  generate
    if (OUT_W < DATA_W) begin : g_narrow
      localparam int SH = DATA_W - OUT_W;
      localparam logic [SH-1:0] HALF = SH'(longint'(1) << (SH - 1));
      localparam logic signed [DATA_W:0] OMAX =
        (DATA_W+1)'((longint'(1) << (OUT_W - 1)) - 1);
      logic signed [DATA_W-1:0] quo;
      logic [SH-1:0]            rem;
      logic                     bump;
      logic signed [DATA_W:0]   rnd;
      assign quo  = core_i >>> SH;
      assign rem  = core_i[SH-1:0];
      // nearest, ties to the even quotient
      assign bump = (rem > HALF) || ((rem == HALF) && quo[0]);
      assign rnd  = {quo[DATA_W-1], quo} + (DATA_W+1)'(bump);
      always_comb begin
        if (rnd > OMAX)       res = OMAX[OUT_W-1:0];
        else if (rnd < -OMAX) res = (-OMAX) >>> 0;
        else                  res = rnd[OUT_W-1:0];
      end
    end else if (OUT_W > DATA_W) begin : g_wide
      localparam int SH = OUT_W - DATA_W;
      assign res = {core_i, {SH{1'b0}}};
    end else begin : g_same
      assign res = core_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sine_o <= '0;
      side_o <= '0;
    end else begin
      sine_o <= res;
      side_o <= side_i;
    end
  end
endmodule

// File: rtl/cordic_sine_gen.sv
`timescale 1ns/1ps
module cordic_sine_gen import cordic_sine_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16,
  parameter int SIDE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       phase_in,
  input  logic [SIDE_W-1:0]       side_in,
  output logic signed [OUT_W-1:0] sine_out,
  output logic [SIDE_W-1:0]       side_out
);
  localparam int XY_W  = DATA_W + FRAC_W + 2;
  localparam int ANG_W = DATA_W + ANG_G + 2;
  localparam logic signed [XY_W-1:0] PK  = XY_W'((longint'(1) << (DATA_W - 1)) - 1);
  localparam logic signed [XY_W-1:0] RND = XY_W'(longint'(1) << (FRAC_W - 1));

  logic signed [XY_W-1:0]  x_p    [DATA_W+1];
  logic signed [XY_W-1:0]  y_p    [DATA_W+1];
  logic signed [ANG_W-1:0] z_p    [DATA_W+1];
  logic [SIDE_W-1:0]       side_p [DATA_W+1];

  // named internal events, observed by the bound checker
  logic signed [ANG_W-1:0]  pre_z;
  logic signed [ANG_W-1:0]  last_z;
  logic signed [XY_W-1:0]   last_x;
  logic signed [XY_W-1:0]   last_y;
  logic signed [XY_W-1:0]   y_rnd;
  logic signed [DATA_W-1:0] core_sine;

  cordic_sine_prerot #(
    .DATA_W(DATA_W), .SIDE_W(SIDE_W), .XY_W(XY_W), .ANG_W(ANG_W)
  ) i_prerot (
    .clk(clk), .rst_n(rst_n), .phase(phase_in), .side(side_in),
    .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0]), .side_o(side_p[0])
  );

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_stage
      cordic_sine_stage #(
        .IDX(g), .DATA_W(DATA_W), .SIDE_W(SIDE_W), .XY_W(XY_W), .ANG_W(ANG_W)
      ) i_stage (
        .clk(clk), .rst_n(rst_n),
        .x_i(x_p[g]), .y_i(y_p[g]), .z_i(z_p[g]), .side_i(side_p[g]),
        .x_o(x_p[g+1]), .y_o(y_p[g+1]), .z_o(z_p[g+1]), .side_o(side_p[g+1])
      );
    end
  endgenerate

  assign pre_z  = z_p[0];
  assign last_z = z_p[DATA_W];
  assign last_x = x_p[DATA_W];
  assign last_y = y_p[DATA_W];

  // drop the guard bits with rounding, clamp to the symmetric sample range
  assign y_rnd = (last_y + RND) >>> FRAC_W;
  always_comb begin
    if (y_rnd > PK)       core_sine = PK[DATA_W-1:0];
    else if (y_rnd < -PK) core_sine = (-PK) >>> 0;
    else                  core_sine = y_rnd[DATA_W-1:0];
  end

  cordic_sine_fmt #(
    .DATA_W(DATA_W), .OUT_W(OUT_W), .SIDE_W(SIDE_W)
  ) i_fmt (
    .clk(clk), .rst_n(rst_n), .core_i(core_sine), .side_i(side_p[DATA_W]),
    .sine_o(sine_out), .side_o(side_out)
  );
endmodule

// File: rtl/cordic_sine_chk.sv
`timescale 1ns/1ps
module cordic_sine_chk import cordic_sine_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16,
  parameter int XY_W   = DATA_W + FRAC_W + 2,
  parameter int ANG_W  = DATA_W + ANG_G + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [ANG_W-1:0]  pre_z,
  input logic signed [ANG_W-1:0]  last_z,
  input logic signed [XY_W-1:0]   last_x,
  input logic signed [XY_W-1:0]   last_y,
  input logic signed [DATA_W-1:0] core_sine,
  input logic signed [OUT_W-1:0]  sine_out
);
  localparam logic signed [ANG_W-1:0] QTR   = ANG_W'(longint'(1) << (DATA_W - 2 + ANG_G));
  localparam logic signed [ANG_W-1:0] RESID = ANG_W'(DATA_W + (1 << (ANG_G + 1)));
  localparam logic signed [XY_W-1:0]  XYLIM =
    XY_W'((longint'(1) << (DATA_W - 1 + FRAC_W)) + (longint'(1) << (FRAC_W + 3)));

  logic signed [ANG_W-1:0]  pre_abs, last_abs;
  logic signed [XY_W-1:0]   x_abs, y_abs;
  logic signed [DATA_W-1:0] core_d;

  assign pre_abs  = pre_z[ANG_W-1]  ? -pre_z  : pre_z;
  assign last_abs = last_z[ANG_W-1] ? -last_z : last_z;
  assign x_abs    = last_x[XY_W-1]  ? -last_x : last_x;
  assign y_abs    = last_y[XY_W-1]  ? -last_y : last_y;

  always_ff @(posedge clk) begin
    if (!rst_n) core_d <= '0;
    else        core_d <= core_sine;
  end

  // R4: the fold leaves at most a quarter turn to rotate
  assert_fold_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_abs <= QTR);

  // R2: the residual angle has converged after the last stage
  assert_converged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_abs <= RESID);

  // R5: internal vector stays inside its headroom
  assert_xy_headroom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (x_abs <= XYLIM) && (y_abs <= XYLIM));

  // R5: the most negative output code never appears
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sine_out != {1'b1, {(OUT_W-1){1'b0}}});

  generate
    if (OUT_W < DATA_W) begin : g_narrow
      localparam int SH = DATA_W - OUT_W;
      localparam logic signed [DATA_W+1:0] HALF = (DATA_W+2)'(longint'(1) << (SH - 1));
      localparam logic signed [OUT_W-1:0]  OMAX = OUT_W'((longint'(1) << (OUT_W - 1)) - 1);
      logic signed [DATA_W+1:0] scaled, err;
      logic near, tie, sat;
      assign scaled = {{2{sine_out[OUT_W-1]}}, sine_out, {SH{1'b0}}};
      assign err    = scaled - {{2{core_d[DATA_W-1]}}, core_d};
      assign near   = (err <= HALF) && (err >= -HALF);
      assign tie    = (err == HALF) || (err == -HALF);
      assign sat    = (sine_out == OMAX) || (sine_out == -OMAX);
      // R6: nearest with ties to even, or a saturated code
      assert_fair_round_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (near && (!tie || !sine_out[0])) || sat);
    end else if (OUT_W > DATA_W) begin : g_wide
      localparam int SH = OUT_W - DATA_W;
      // R7: widening is a pure left shift
      assert_widen_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sine_out == {core_d, {SH{1'b0}}});
    end else begin : g_same
      // R8: equal widths pass the word through untouched
      assert_pass_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sine_out == core_d);
    end
  endgenerate
endmodule

bind cordic_sine_gen cordic_sine_chk #(
  .DATA_W(DATA_W), .OUT_W(OUT_W), .XY_W(XY_W), .ANG_W(ANG_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pre_z(pre_z), .last_z(last_z),
  .last_x(last_x), .last_y(last_y), .core_sine(core_sine), .sine_out(sine_out)
);

// File: tb/cordic_sine_harness.sv
`timescale 1ns/1ps
module cordic_sine_harness #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16,
  parameter int SIDE_W = 8,
  parameter int N_STIM = 600
) (
  input  logic clk,
  output int   n_checks,
  output int   n_fails,
  output logic done
);
  localparam int  LAT  = DATA_W + 2;
  localparam int  FULL = 1 << DATA_W;
  localparam int  Q    = FULL / 4;
  localparam int  SH   = (OUT_W > DATA_W) ? OUT_W - DATA_W : 0;
  localparam real AMP  = (2.0 ** (DATA_W - 1) - 3.0) * (2.0 ** (OUT_W - DATA_W));
  localparam real TOL  = (OUT_W > DATA_W) ? 4.0 * (2.0 ** SH) :
                         ((OUT_W == DATA_W) ? 4.0 : 2.0);
  localparam int  MINNEG = -(1 << (OUT_W - 1));

  logic                    rst_n;
  logic [DATA_W-1:0]       phase_in;
  logic [SIDE_W-1:0]       side_in;
  logic signed [OUT_W-1:0] sine_out;
  logic [SIDE_W-1:0]       side_out;

  cordic_sine_gen #(.DATA_W(DATA_W), .OUT_W(OUT_W), .SIDE_W(SIDE_W)) i_cordic_sine_gen (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .side_in(side_in),
    .sine_out(sine_out), .side_out(side_out)
  );

  // reference model: what was captured, in order; -1 marks a reset slot
  int ph_q[$];
  int sd_q[$];
  int cl_q[$];
  int unsigned rng;

  function automatic string mode_tag();
    if (OUT_W < DATA_W)      return "R6";
    else if (OUT_W > DATA_W) return "R7";
    else                     return "R8";
  endfunction

  function automatic int corner(input int k);
    case (k)
      0: return 0;          1: return Q;          2: return 2 * Q;
      3: return 3 * Q;      4: return Q - 1;      5: return Q + 1;
      6: return 2 * Q - 1;  7: return 2 * Q + 1;  8: return 3 * Q - 1;
      9: return 3 * Q + 1;  10: return FULL - 1;  default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s (DATA_W=%0d OUT_W=%0d): actual %0.3f expected %0.3f",
               req, what, DATA_W, OUT_W, act, exp);
    end
  endtask

  task automatic compare_now();
    int  v, sv, ph, sd, cl;
    real ex, err;
    v  = sine_out;
    sv = int'(side_out);
    ph = ph_q.pop_front();
    sd = sd_q.pop_front();
    cl = cl_q.pop_front();
    if (ph < 0) begin
      check(v == 0,  "R1", "sample before first result", v, 0);
      check(sv == 0, "R1", "side before first result", sv, 0);
    end else begin
      ex  = AMP * $sin(6.283185307179586 * real'(ph) / real'(FULL));
      err = real'(v) - ex;
      if (err < 0.0) err = -err;
      if (cl == 0)      check(err <= TOL, "R4", "quadrant corner sample", v, ex);
      else if (cl == 1) check(err <= TOL, "R2", "sweep sample", v, ex);
      else              check(err <= TOL, mode_tag(), "random sample", v, ex);
      check(sv == sd, "R3", "side word alignment", sv, sd);
      check(v != MINNEG, "R5", "most negative code", v, MINNEG + 1);
      if (OUT_W > DATA_W)
        check((v & ((1 << SH) - 1)) == 0, "R7", "low bits after widening",
              v & ((1 << SH) - 1), 0);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    phase_in = '0;
    side_in  = '0;
    rng      = 32'h1357_9bdf;
    repeat (4) @(negedge clk);
    check(sine_out == 0, "R1", "sample in reset", sine_out, 0);
    check(side_out == 0, "R1", "side in reset", side_out, 0);
    for (int k = 0; k < LAT; k++) begin
      ph_q.push_back(-1);
      sd_q.push_back(0);
      cl_q.push_back(0);
    end
    rst_n = 1'b1;
    for (int step = 0; step < N_STIM + LAT; step++) begin
      int ph, sd, cl;
      compare_now();
      if (step < 12) begin
        ph = corner(step);
        cl = 0;
      end else if (step < 12 + 256) begin
        ph = ((step - 12) * (FULL / 256) + (step - 12) * 5) % FULL;
        cl = 1;
      end else begin
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        ph  = int'(rng % FULL);
        cl  = 2;
      end
      sd = (step * 37 + 11) & ((1 << SIDE_W) - 1);
      phase_in = DATA_W'(ph);
      side_in  = SIDE_W'(sd);
      ph_q.push_back(ph);
      sd_q.push_back(sd);
      cl_q.push_back(cl);
      @(negedge clk);
    end
    done = 1'b1;
  end
endmodule

// File: tb/test_cordic_sine_gen.sv
`timescale 1ns/1ps
module test_cordic_sine_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int   c_eq, f_eq, c_wd, f_wd, c_nr, f_nr;
  logic d_eq, d_wd, d_nr;

  cordic_sine_harness #(.DATA_W(16), .OUT_W(16), .SIDE_W(8))  h_equal  (
    .clk(clk), .n_checks(c_eq), .n_fails(f_eq), .done(d_eq));
  cordic_sine_harness #(.DATA_W(14), .OUT_W(18), .SIDE_W(6))  h_widen  (
    .clk(clk), .n_checks(c_wd), .n_fails(f_wd), .done(d_wd));
  cordic_sine_harness #(.DATA_W(20), .OUT_W(12), .SIDE_W(10)) h_narrow (
    .clk(clk), .n_checks(c_nr), .n_fails(f_nr), .done(d_nr));

  initial begin
    int total, failed;
    for (int cyc = 0; cyc < 200000; cyc++) begin
      @(posedge clk);
      if (d_eq && d_wd && d_nr) break;
    end
    total  = c_eq + c_wd + c_nr;
    failed = f_eq + f_wd + f_nr;
    if (!(d_eq && d_wd && d_nr)) begin
      total++;
      failed++;
      $display("FAIL watchdog: run did not finish, actual done=%0d%0d%0d expected 111",
               d_eq, d_wd, d_nr);
    end
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule